// File: doc/BRIEF.md
# Multi-mode PWM timer channel

This block produces a pulse-width-modulated reference signal from one counter and one compare channel. The counter runs from zero up to a programmable limit, from that limit down to zero, or up and back down in a triangle. The reference output is a comparison of the count with a programmable threshold, so the pulse is left-justified in the up-counting mode, right-justified in the down-counting mode and centred in the triangle mode. A match flag marks the cycles where the count equals the threshold, and an update pulse marks the cycles where a counting period turns over.

The limit and threshold inputs pass through shadow copies. While the counter runs, those copies load only on an update cycle, so a new setting always starts on a period boundary. While the counter is stopped, they follow the inputs on every clock. The reference output, the match flag and the update pulse are decoded from registered state. They are valid in the cycle that the count output shows.

Top module: `pwm_timer`

## Requirements
- R1: With `center_sel` = 00 and `dir_sel` = 0, an enabled counter steps up by one per clock. In the cycle where the count is at or above the active limit, `upd_pulse` is 1 and the next count is 0.
- R2: With `center_sel` = 00 and `dir_sel` = 1, an enabled counter steps down by one per clock. In the cycle where the count is 0, `upd_pulse` is 1 and the next count is the active limit.
- R3: Any nonzero `center_sel` selects triangle counting, where `dir_sel` has no effect. The count goes 0, 1, …, limit, limit-1, …, 0, 1, … and visits each end once per turn. `dir_down` is 0 while rising and 1 while falling, and it is 0 at the top value. `upd_pulse` is 1 at the top value and at the bottom value.
- R4: In up-counting mode `pwm_ref` equals (count < threshold). A threshold above the limit gives a constant 1, and a threshold of 0 gives a constant 0.
- R5: In down-counting mode `pwm_ref` equals (count <= threshold). A threshold above the limit gives a constant 1, and a threshold of 0 still gives 1 while the count is 0, so the duty cycle never reaches zero.
- R6: In triangle mode `pwm_ref` equals (count < threshold) in both directions. All three nonzero `center_sel` values give the same waveform.
- R7: `cmp_flag` is 1 in an enabled cycle where the count equals the threshold. In the edge modes every match counts. In triangle mode, `center_sel` = 01 counts only rising matches, 10 counts only falling matches and 11 counts both, where the direction is the one `dir_down` shows.
- R8: While enabled, the active limit and threshold load from `reload_in` and `cmp_in` only in an update cycle, so a change never alters the running period. While disabled, they load on every clock.
- R9: With `en` = 0 the count and the direction stay frozen, and `upd_pulse` and `cmp_flag` are 0.
- R10: While `rst_n` is low, the count, the triangle direction and both shadow values are 0. In up-counting mode this gives `pwm_ref` = 0, `upd_pulse` = 0, `cmp_flag` = 0 and `dir_down` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Count enable |
| dir_sel | input | 1 | Edge-mode direction, 0 up and 1 down |
| center_sel | input | 2 | 00 edge modes, nonzero triangle mode with flag qualifier |
| reload_in | input | CNT_W | Counter limit, goes to its shadow |
| cmp_in | input | CNT_W | Compare threshold, goes to its shadow |
| pwm_ref | output | 1 | Reference PWM output |
| cmp_flag | output | 1 | Compare match pulse |
| upd_pulse | output | 1 | Period turnover pulse |
| count | output | CNT_W | Current count |
| dir_down | output | 1 | Current counting direction, 1 when falling |

## Verification
The embedded properties check, on every cycle, the single counter steps in each mode: the up increment, the down reload, the turn at the top of the triangle, and the freeze while disabled. They also check that the shadows stay steady between update cycles, that the down mode stays high at a count of zero, that a zero threshold gives a low output in the other modes, and that a rising-only flag never fires while falling. Only the bench scenarios can show whole-period properties. These are the duty count for each threshold and direction, the number of flags per period for each qualifier, the two turnovers per triangle, a mid-period setting change that waits for the boundary, and a direction input that has no effect in triangle mode.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic [1:0] {
    CNT_UP     = 2'd0,
    CNT_DOWN   = 2'd1,
    CNT_CENTER = 2'd2
  } cnt_mode_e;

  // Flag qualifier encodings for triangle counting
  localparam logic [1:0] CFLAG_UP   = 2'b01;
  localparam logic [1:0] CFLAG_DOWN = 2'b10;

  function automatic cnt_mode_e decode_mode(input logic dir_sel, input logic [1:0] center_sel);
    if (center_sel != 2'b00) return CNT_CENTER;
    else if (dir_sel)        return CNT_DOWN;
    else                     return CNT_UP;
  endfunction

endpackage

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] reload_in,
  input  logic [CNT_W-1:0] cmp_in,
  output logic [CNT_W-1:0] reload_q,
  output logic [CNT_W-1:0] cmp_q
);

  logic [CNT_W-1:0] reload_d;
  logic [CNT_W-1:0] cmp_d;

  always_comb begin
    reload_d = reload_q;
    cmp_d    = cmp_q;
    if (load) begin
      reload_d = reload_in;
      cmp_d    = cmp_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      cmp_q    <= '0;
    end else begin
      reload_q <= reload_d;
      cmp_q    <= cmp_d;
    end
  end

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  cnt_mode_e        mode,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt_q,
  output logic             dir_q,
  output logic             upd
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_d;
  logic             dir_d;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    upd   = 1'b0;
    if (mode != CNT_CENTER) dir_d = 1'b0;
    if (en) begin
      case (mode)
        CNT_UP: begin
          if (cnt_q >= reload) begin
            cnt_d = '0;
            upd   = 1'b1;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
        CNT_DOWN: begin
          if (cnt_q == '0) begin
            cnt_d = reload;
            upd   = 1'b1;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
        default: begin
          if (!dir_q) begin
            if (cnt_q >= reload) begin
              upd   = 1'b1;
              dir_d = 1'b1;
              cnt_d = (reload == '0) ? '0 : reload - ONE;
            end else begin
              cnt_d = cnt_q + ONE;
            end
          end else begin
            if (cnt_q == '0) begin
              upd   = 1'b1;
              dir_d = 1'b0;
              cnt_d = (reload == '0) ? '0 : ONE;
            end else begin
              cnt_d = cnt_q - ONE;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  a_r1_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == CNT_UP && cnt_q < reload) |=> (cnt_q == $past(cnt_q) + ONE));

  a_r2_down_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == CNT_DOWN && cnt_q == '0) |=> (cnt_q == $past(reload)));

  a_r3_top_turn: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == CNT_CENTER && !dir_q && cnt_q >= reload && reload != '0)
      |=> (dir_q && cnt_q == $past(reload) - ONE));

  a_r3_edge_dir_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != CNT_CENTER) |=> !dir_q);

  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt_q));

endmodule

// File: rtl/pwm_compare.sv
module pwm_compare
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  cnt_mode_e        mode,
  input  logic [1:0]       center_sel,
  input  logic             falling,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  output logic             ref_o,
  output logic             flag_o
);

  logic match;
  logic dir_ok;

  always_comb begin
    if (mode == CNT_DOWN) ref_o = (cnt <= cmp);
    else                  ref_o = (cnt < cmp);
  end

  always_comb begin
    match = en && (cnt == cmp);
    if (mode == CNT_CENTER)
      dir_ok = (center_sel[0] && !falling) || (center_sel[1] && falling);
    else
      dir_ok = 1'b1;
    flag_o = match && dir_ok;
  end

  a_r5_no_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CNT_DOWN && cnt == '0) |-> ref_o);

  a_r4_zero_cmp_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != CNT_DOWN && cmp == '0) |-> !ref_o);

  a_r7_rising_only: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && mode == CNT_CENTER && center_sel == CFLAG_UP) |-> !falling);

  a_r7_falling_only: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && mode == CNT_CENTER && center_sel == CFLAG_DOWN) |-> falling);

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             dir_sel,
  input  logic [1:0]       center_sel,
  input  logic [CNT_W-1:0] reload_in,
  input  logic [CNT_W-1:0] cmp_in,
  output logic             pwm_ref,
  output logic             cmp_flag,
  output logic             upd_pulse,
  output logic [CNT_W-1:0] count,
  output logic             dir_down
);

  cnt_mode_e        mode;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tri_dir;
  logic             upd;
  logic             shadow_load;

  assign mode        = decode_mode(dir_sel, center_sel);
  assign shadow_load = upd || !en;
  assign dir_down    = (mode == CNT_CENTER) ? tri_dir : dir_sel;
  assign count       = cnt_q;
  assign upd_pulse   = upd;

  pwm_shadow #(.CNT_W(CNT_W)) i_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (shadow_load),
    .reload_in (reload_in),
    .cmp_in    (cmp_in),
    .reload_q  (reload_q),
    .cmp_q     (cmp_q)
  );

  pwm_counter #(.CNT_W(CNT_W)) i_counter (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .mode   (mode),
    .reload (reload_q),
    .cnt_q  (cnt_q),
    .dir_q  (tri_dir),
    .upd    (upd)
  );

  pwm_compare #(.CNT_W(CNT_W)) i_compare (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .mode       (mode),
    .center_sel (center_sel),
    .falling    (dir_down),
    .cnt        (cnt_q),
    .cmp        (cmp_q),
    .ref_o      (pwm_ref),
    .flag_o     (cmp_flag)
  );

  a_r8_shadow_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !upd) |=> ($stable(reload_q) && $stable(cmp_q)));

  a_r9_no_pulses_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!upd_pulse && !cmp_flag));

endmodule

// File: tb/test_pwm_timer.sv
module test_pwm_timer;

  localparam int W = 16;
  localparam int WATCHDOG_CYCLES = 20000;

  typedef struct packed {
    logic        dir;
    logic [1:0]  cs;
    logic [15:0] arr;
    logic [15:0] cmp;
    logic [7:0]  high;
    logic [7:0]  flags;
    logic [7:0]  upds;
  } vec_t;

  // dir, center_sel, limit, threshold, expected high cycles, flags, updates per window
  localparam vec_t VECS [14] = '{
    '{1'b0, 2'b00, 16'd8,  16'd3,  8'd6,  8'd2, 8'd2},  // R4
    '{1'b0, 2'b00, 16'd8,  16'd0,  8'd0,  8'd2, 8'd2},  // R4 zero threshold
    '{1'b0, 2'b00, 16'd8,  16'd9,  8'd18, 8'd0, 8'd2},  // R4 threshold above limit
    '{1'b0, 2'b00, 16'd8,  16'd8,  8'd16, 8'd2, 8'd2},  // R4
    '{1'b1, 2'b00, 16'd8,  16'd3,  8'd8,  8'd2, 8'd2},  // R5
    '{1'b1, 2'b00, 16'd8,  16'd0,  8'd2,  8'd2, 8'd2},  // R5 no zero duty
    '{1'b1, 2'b00, 16'd8,  16'd12, 8'd18, 8'd0, 8'd2},  // R5 above limit
    '{1'b0, 2'b01, 16'd8,  16'd3,  8'd5,  8'd1, 8'd2},  // R6 R7 rising only
    '{1'b0, 2'b10, 16'd8,  16'd3,  8'd5,  8'd1, 8'd2},  // R6 R7 falling only
    '{1'b0, 2'b11, 16'd8,  16'd3,  8'd5,  8'd2, 8'd2},  // R6 R7 both
    '{1'b0, 2'b11, 16'd8,  16'd8,  8'd15, 8'd1, 8'd2},  // R7 top is rising
    '{1'b0, 2'b10, 16'd8,  16'd0,  8'd0,  8'd1, 8'd2},  // R7 bottom is falling
    '{1'b1, 2'b11, 16'd5,  16'd2,  8'd3,  8'd2, 8'd2},  // R3 dir_sel ignored
    '{1'b0, 2'b01, 16'd4,  16'd9,  8'd8,  8'd0, 8'd2}   // R6 above limit
  };

  logic         clk;
  logic         rst_n;
  logic         en;
  logic         dir_sel;
  logic [1:0]   center_sel;
  logic [W-1:0] reload_in;
  logic [W-1:0] cmp_in;
  logic         pwm_ref;
  logic         cmp_flag;
  logic         upd_pulse;
  logic [W-1:0] count;
  logic         dir_down;

  int checks;
  int failures;
  bit finished;

  pwm_timer #(.CNT_W(W)) i_pwm_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .dir_sel    (dir_sel),
    .center_sel (center_sel),
    .reload_in  (reload_in),
    .cmp_in     (cmp_in),
    .pwm_ref    (pwm_ref),
    .cmp_flag   (cmp_flag),
    .upd_pulse  (upd_pulse),
    .count      (count),
    .dir_down   (dir_down)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input string what, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Reset, program, load shadows while stopped, then enable; returns at the cycle-0 sample point
  task automatic start(input logic d, input logic [1:0] cs, input int arr, input int cmp);
    @(negedge clk);
    en         = 1'b0;
    rst_n      = 1'b0;
    dir_sel    = d;
    center_sel = cs;
    reload_in  = W'(arr);
    cmp_in     = W'(cmp);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    en = 1'b1;
    #0.5;
  endtask

  task automatic step();
    @(negedge clk);
    #0.5;
  endtask

  initial begin
    #(WATCHDOG_CYCLES * 5.0);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end

  initial begin
    checks     = 0;
    failures   = 0;
    finished   = 1'b0;
    rst_n      = 1'b0;
    en         = 1'b0;
    dir_sel    = 1'b0;
    center_sel = 2'b00;
    reload_in  = '0;
    cmp_in     = '0;

    // R10: reset state
    #12;
    check("R10", "count in reset", int'(count), 0);
    check("R10", "pwm_ref in reset", int'(pwm_ref), 0);
    check("R10", "upd_pulse in reset", int'(upd_pulse), 0);
    check("R10", "cmp_flag in reset", int'(cmp_flag), 0);
    check("R10", "dir_down in reset", int'(dir_down), 0);

    // Table walk: window skips cycle 0 and spans two periods
    for (int v = 0; v < 14; v++) begin
      int len;
      int hi;
      int fl;
      int up;
      start(VECS[v].dir, VECS[v].cs, int'(VECS[v].arr), int'(VECS[v].cmp));
      len = (VECS[v].cs != 2'b00) ? 2 * int'(VECS[v].arr) : 2 * (int'(VECS[v].arr) + 1);
      hi = 0; fl = 0; up = 0;
      for (int k = 0; k < len; k++) begin
        step();
        hi += int'(pwm_ref);
        fl += int'(cmp_flag);
        up += int'(upd_pulse);
      end
      check("R4/R5/R6 duty", $sformatf("vector %0d high cycles", v), hi, int'(VECS[v].high));
      check("R7", $sformatf("vector %0d flags", v), fl, int'(VECS[v].flags));
      check("R1/R2/R3", $sformatf("vector %0d updates", v), up, int'(VECS[v].upds));
    end

    // R1 R4: up-counting sequence, limit 3 threshold 2
    start(1'b0, 2'b00, 3, 2);
    for (int k = 0; k < 8; k++) begin
      int e;
      if (k > 0) step();
      e = k % 4;
      check("R1", $sformatf("up count k=%0d", k), int'(count), e);
      check("R1", $sformatf("up update k=%0d", k), int'(upd_pulse), (e == 3) ? 1 : 0);
      check("R4", $sformatf("up ref k=%0d", k), int'(pwm_ref), (e < 2) ? 1 : 0);
    end

    // R2 R5: down-counting sequence, limit 3 threshold 1
    start(1'b1, 2'b00, 3, 1);
    for (int k = 0; k < 8; k++) begin
      int e;
      if (k > 0) step();
      e = (4 - (k % 4)) % 4;
      check("R2", $sformatf("down count k=%0d", k), int'(count), e);
      check("R2", $sformatf("down update k=%0d", k), int'(upd_pulse), (e == 0) ? 1 : 0);
      check("R5", $sformatf("down ref k=%0d", k), int'(pwm_ref), (e <= 1) ? 1 : 0);
    end

    // R3 R7: triangle, limit 3 threshold 2, both-direction flags, dir_sel held at 1
    start(1'b1, 2'b11, 3, 2);
    for (int k = 0; k < 12; k++) begin
      int p;
      int e;
      int fall;
      if (k > 0) step();
      p = k % 6;
      e = (p <= 3) ? p : 6 - p;
      fall = ((p >= 4) || (p == 0 && k > 0)) ? 1 : 0;
      check("R3", $sformatf("tri count k=%0d", k), int'(count), e);
      check("R3", $sformatf("tri dir k=%0d", k), int'(dir_down), fall);
      check("R3", $sformatf("tri update k=%0d", k), int'(upd_pulse),
            ((p == 3) || (p == 0 && k > 0)) ? 1 : 0);
      check("R7", $sformatf("tri flag k=%0d", k), int'(cmp_flag), (e == 2) ? 1 : 0);
    end

    // R8: mid-period change waits for the boundary
    start(1'b0, 2'b00, 8, 3);
    for (int k = 0; k <= 16; k++) begin
      if (k > 0) step();
      if (k == 2) begin
        cmp_in    = W'(6);
        reload_in = W'(4);
      end
      if (k == 3) check("R8", "old threshold still used", int'(pwm_ref), 0);
      if (k == 8) check("R8", "old limit reached", int'(count), 8);
      if (k == 9) check("R8", "new threshold after update", int'(pwm_ref), 1);
      if (k == 13) check("R8", "new limit reached", int'(count), 4);
      if (k == 14) check("R8", "wrap at new limit", int'(count), 0);
    end

    // R9 R8: stopped counter freezes; shadows follow inputs while stopped
    en     = 1'b0;
    cmp_in = W'(2);
    for (int k = 0; k < 3; k++) begin
      step();
      check("R9", $sformatf("frozen count %0d", k), int'(count), 2);
      check("R9", $sformatf("no update while stopped %0d", k), int'(upd_pulse), 0);
      check("R9", $sformatf("no flag while stopped %0d", k), int'(cmp_flag), 0);
    end
    check("R8", "threshold loaded while stopped", int'(pwm_ref), 0);
    en = 1'b1;
    #0.5;
    check("R7", "flag on match once enabled", int'(cmp_flag), 1);
    step();
    check("R9", "resumes counting", int'(count), 3);

    report();
  end

endmodule